// File: doc/BRIEF.md
# Input Port Change-Detect Interrupt Generator

This block raises an interrupt when the inputs of a general-purpose port on a serial-bus I/O expander move away from their last-read values. It keeps one snapshot of the port, taken from the synchronized inputs. It drives an active-low interrupt line for as long as any enabled input differs from that snapshot. The host bus is reduced to two pulses. A read strobe marks a port read, and a stop pulse marks the end of a bus transaction. Either pulse reloads the snapshot and so clears the interrupt.

There is no latching status bit. The interrupt is a live mismatch indicator. If an input changes and then returns to its snapshot value before the host reads the port, the line goes low briefly and then releases, and nothing records that the change happened. If a change reaches the synchronizer output in the same cycle as a read, the snapshot absorbs it and no interrupt follows. A per-bit enable mask removes chosen inputs from the compare.

Top module: `port_chg_irq`

## Requirements
- R1: When any enabled synchronized input differs from the snapshot and no reload is requested, `int_n` is 0 on the next clock. A pin change driven before clock edge k shows on `int_n` after edge k+2.
- R2: When every enabled synchronized input equals the snapshot, `int_n` is 1 on the next clock. A pin that returns to its snapshot value therefore releases the interrupt without any read.
- R3: A cycle with `rd_strobe` high loads the snapshot with that cycle's synchronized inputs, and `int_n` is 1 after that edge.
- R4: A cycle with `stop_pulse` high reloads the snapshot exactly as a read does, and `int_n` is 1 after that edge.
- R5: When an input's synchronized value changes on the same edge that samples `rd_strobe`, the snapshot keeps the value that was present before that edge, and the change raises the interrupt on the following edge. When the read is sampled one edge after the synchronized change, the snapshot takes the new value and no interrupt is raised.
- R6: `int_n` is active low. Under reset it is 1. The snapshot and both synchronizer stages load the raw pins, so with stable pins the line stays 1 after reset.
- R7: The mask resets to all ones, meaning every bit is compared. A cycle with `mask_we` high loads `mask_wdata`. A bit with mask 0 never causes an interrupt, and a newly written mask affects `int_n` from the second edge after the write.
- R8: The interrupt does not latch. A pin pulse that leaves and returns to its snapshot value between reads leaves `int_n` at 1 after the pulse has passed the synchronizer, and a following read also leaves it at 1.
- R9: `port_value` shows the pins delayed by two clock edges through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | WIDTH | Asynchronous port pins |
| rd_strobe | input | 1 | One-cycle pulse for a host read of the port |
| stop_pulse | input | 1 | One-cycle pulse for a bus stop event |
| mask_we | input | 1 | Load strobe for the compare-enable mask |
| mask_wdata | input | WIDTH | New mask value; a 1 enables the bit |
| port_value | output | WIDTH | Synchronized pin values, as returned to the host on a read |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The hardest situations to reach are a read that coincides with the synchronized edge of an input, and a pulse that is gone before any read. Both exist only inside a window of one or two cycles. The stimulus drives pins on falling clock edges and counts the two synchronizer stages. It places a read exactly on the cycle before, and the cycle after, the synchronized change. It also places a one-cycle pin pulse that returns before the next read. A long random phase of pin flips, reads, stops and mask writes is then compared on every clock against a queue-based model.

// File: rtl/chg_pkg.sv
package chg_pkg;
  // cause of a snapshot reload, for readability in the snapshot block
  typedef enum logic [1:0] {
    RLD_NONE = 2'b00,
    RLD_READ = 2'b01,
    RLD_STOP = 2'b10,
    RLD_BOTH = 2'b11
  } reload_e;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] sync_q
);
  localparam int TOP = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{pins_in[b]}};
      else     chain <= {chain[STAGES-2:0], pins_in[b]};
    end
    assign sync_q[b] = chain[TOP];
  end

  // cycles since reset, used only to arm the latency check
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    // R9
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0) |-> (sync_q == $past(pins_in, 2)));
  end
endmodule

// File: rtl/chg_snapshot.sv
module chg_snapshot
  import chg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  input  logic [WIDTH-1:0] sync_q,
  input  logic             rd_strobe,
  input  logic             stop_pulse,
  input  logic             mask_we,
  input  logic [WIDTH-1:0] mask_wdata,
  output logic [WIDTH-1:0] snap_q,
  output logic [WIDTH-1:0] snap_d,
  output logic [WIDTH-1:0] mask_q,
  output logic             reload
);
  reload_e cause;

  always_comb begin
    cause  = reload_e'({stop_pulse, rd_strobe});
    reload = (cause != RLD_NONE);
    snap_d = reload ? sync_q : snap_q;
  end

  always_ff @(posedge clk) begin
    if (rst) snap_q <= pins_in;
    else     snap_q <= snap_d;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  // R4
  stop_reload_chk: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> (snap_q == $past(sync_q)));

  // R3
  read_reload_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (snap_q == $past(sync_q)));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(mask_wdata)));
endmodule

// File: rtl/chg_compare.sv
module chg_compare #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_q,
  input  logic [WIDTH-1:0] snap_q,
  input  logic [WIDTH-1:0] snap_d,
  input  logic [WIDTH-1:0] mask_q,
  input  logic             reload,
  output logic             int_n
);
  logic [WIDTH-1:0] diff;
  logic             any_diff;

  always_comb begin
    diff     = (sync_q ^ snap_d) & mask_q;
    any_diff = |diff;
  end

  always_ff @(posedge clk) begin
    if (rst) int_n <= 1'b1;
    else     int_n <= ~any_diff;
  end

  // R1
  mismatch_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (!reload && ((sync_q ^ snap_q) & mask_q) != '0) |=> !int_n);

  // R2
  match_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (((sync_q ^ snap_q) & mask_q) == '0) |=> int_n);

  // R6
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> int_n);
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq
  import chg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_in,
  input  logic             rd_strobe,
  input  logic             stop_pulse,
  input  logic             mask_we,
  input  logic [WIDTH-1:0] mask_wdata,
  output logic [WIDTH-1:0] port_value,
  output logic             int_n
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] snap_q;
  logic [WIDTH-1:0] snap_d;
  logic [WIDTH-1:0] mask_q;
  logic             reload;

  chg_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pins_in (pins_in),
    .sync_q  (sync_q)
  );

  chg_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk        (clk),
    .rst        (rst),
    .pins_in    (pins_in),
    .sync_q     (sync_q),
    .rd_strobe  (rd_strobe),
    .stop_pulse (stop_pulse),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .snap_q     (snap_q),
    .snap_d     (snap_d),
    .mask_q     (mask_q),
    .reload     (reload)
  );

  chg_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .sync_q (sync_q),
    .snap_q (snap_q),
    .snap_d (snap_d),
    .mask_q (mask_q),
    .reload (reload),
    .int_n  (int_n)
  );

  assign port_value = sync_q;

  // R3
  host_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || stop_pulse) |=> int_n);
endmodule

// File: tb/port_chg_irq_test.sv
module port_chg_irq_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pins_in = 16'hA5C3;
  logic         rd_strobe = 1'b0;
  logic         stop_pulse = 1'b0;
  logic         mask_we = 1'b0;
  logic [W-1:0] mask_wdata = '0;
  logic [W-1:0] port_value;
  logic         int_n;

  always #10 clk = ~clk;

  port_chg_irq #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .rd_strobe(rd_strobe),
    .stop_pulse(stop_pulse), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .port_value(port_value), .int_n(int_n)
  );

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  // behavioural reference: pin history queue, snapshot, mask, expected line
  logic [W-1:0] hist[$];
  logic [W-1:0] m_snap;
  logic [W-1:0] m_mask;
  logic         m_int_n;
  bit           m_valid = 1'b0;

  always @(posedge clk) begin
    logic [W-1:0] cur;
    if (rst) begin
      hist = {};
      hist.push_back(pins_in);
      hist.push_back(pins_in);
      m_snap  = pins_in;
      m_mask  = '1;
      m_int_n = 1'b1;
      m_valid = 1'b1;
    end else if (m_valid) begin
      cur = hist[0];
      if (rd_strobe || stop_pulse) m_snap = cur;
      m_int_n = (((cur ^ m_snap) & m_mask) == '0);
      if (mask_we) m_mask = mask_wdata;
      void'(hist.pop_front());
      hist.push_back(pins_in);
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_valid && !done) begin
      chk("R1 per-cycle int_n", {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, m_int_n});
      chk("R9 per-cycle port_value", port_value, hist[0]);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_int(input string req, input logic exp);
    chk(req, {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, exp});
  endtask

  task automatic pulse_rd;
    rd_strobe = 1'b1; cyc(1); rd_strobe = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R6: idle after reset with stable pins
    chk_int("R6 reset idle", 1'b1);
    cyc(2);
    chk_int("R6 stays idle", 1'b1);
    // R9: port shows the pins
    chk("R9 port_value", port_value, 16'hA5C3);

    // R1: flip bit0, visible after the third edge
    pins_in[0] = ~pins_in[0];
    cyc(2);
    chk_int("R1 not yet", 1'b1);
    cyc(1);
    chk_int("R1 asserted", 1'b0);
    // R3: read clears
    pulse_rd();
    chk_int("R3 read clears", 1'b1);
    cyc(3);
    chk_int("R3 stays clear", 1'b1);

    // R2: change then restore without a read
    pins_in[3] = ~pins_in[3];
    cyc(3);
    chk_int("R2 asserted", 1'b0);
    pins_in[3] = ~pins_in[3];
    cyc(3);
    chk_int("R2 self-release", 1'b1);

    // R8: one-cycle pulse between reads
    pins_in[5] = ~pins_in[5];
    cyc(1);
    pins_in[5] = ~pins_in[5];
    cyc(2);
    chk_int("R8 transient low", 1'b0);
    cyc(3);
    chk_int("R8 no trace left", 1'b1);
    pulse_rd();
    cyc(2);
    chk_int("R8 after read", 1'b1);

    // R4: stop event clears
    pins_in[1] = ~pins_in[1];
    cyc(3);
    chk_int("R4 asserted", 1'b0);
    stop_pulse = 1'b1; cyc(1); stop_pulse = 1'b0;
    chk_int("R4 stop clears", 1'b1);

    // R7: mask out bit2
    mask_wdata = ~(16'h1 << 2);
    mask_we = 1'b1; cyc(1); mask_we = 1'b0;
    pins_in[2] = ~pins_in[2];
    cyc(4);
    chk_int("R7 masked bit ignored", 1'b1);
    mask_wdata = '1;
    mask_we = 1'b1; cyc(1); mask_we = 1'b0;
    chk_int("R7 mask write not yet", 1'b1);
    cyc(1);
    chk_int("R7 re-enabled bit fires", 1'b0);
    pulse_rd();

    // R5 case a: read sampled after the synchronized change is absorbed
    cyc(2);
    pins_in[4] = ~pins_in[4];
    cyc(2);
    pulse_rd();
    chk_int("R5 change absorbed by read", 1'b1);
    cyc(3);
    chk_int("R5 no later interrupt", 1'b1);

    // R5 case b: read on the edge where the synchronized value changes
    pins_in[6] = ~pins_in[6];
    cyc(1);
    pulse_rd();
    chk_int("R5 read before change", 1'b1);
    cyc(1);
    chk_int("R5 change after read fires", 1'b0);
    pulse_rd();

    // random phase, compared every cycle by the reference model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) pins_in[$urandom % W] = ~pins_in[$urandom % W];
      rd_strobe  = (($urandom % 12) == 0);
      stop_pulse = (($urandom % 25) == 0);
      mask_we    = (($urandom % 60) == 0);
      mask_wdata = W'($urandom) | W'($urandom);
    end
    @(negedge clk);
    rd_strobe = 1'b0; stop_pulse = 1'b0; mask_we = 1'b0;
    cyc(4);
    finish_run();
  end
endmodule